// File: doc/BRIEF.md
# Three-Lane Seven-to-One Serial Deserializer

This block turns three serial lanes back into one 21-bit parallel word. Each lane carries seven bits in every period of a frame clock. A bit clock that runs at seven times the frame rate is supplied from outside. The frame clock is sampled in the bit-clock domain, and each rising edge of the frame clock starts a new frame. Slots are counted from that edge. Every lane shifts its seven bits into its own capture register, and the assembled word passes through a staging register before it reaches the output register. A strobe follows the frame clock, so its rising edge falls inside the window in which the output word is stable.

The block also handles the cases where the link is not running normally. An active-low power-down input forces every output low and clears the internal state. The design does nothing special for idle lanes: they read as ones, so a running frame clock with idle lanes gives an all-ones word. When the frame clock stops, the block holds the last delivered word and parks the strobe low. It starts delivering words again only after it has received a complete frame aligned to a frame-clock edge.

Top module: `tri_lane_deser`

## Requirements
- R1: While rst_ni is low, data_o is all zeros and strobe_o is low.
- R2: Slot j of lane k is placed in data_o bit 7*k+j. Slot 0 is the lane value sampled on the first bit-clock edge at which frame_clk_i is seen high after being low. Slot j is sampled j bit clocks later.
- R3: A frame whose slot 0 is sampled on bit-clock edge n appears on data_o just after edge n+14, which is two frame periods later.
- R4: strobe_o is frame_clk_i delayed by two bit-clock edges. Its rising edge therefore comes one bit clock after data_o updates.
- R5: data_o changes only on the bit-clock edge that detects a rising frame edge. It is stable for the rest of the frame.
- R6: Lanes held high while the frame clock runs give an all-ones word, with the normal latency.
- R7: If 16 bit-clock edges pass with no rising frame edge, strobe_o goes low and data_o holds its last word. After 15 such edges strobe_o still follows the frame clock. When the frame clock returns, the first frame that starts on a rising frame edge appears two frames later, and data_o holds until then.
- R8: While pwr_dn_ni is low, data_o and strobe_o are low in the same cycle. After release, data_o stays zero until the first full frame after release is delivered, two frames after it starts.
- R9: A frame with fewer than seven slots is discarded. The word before it is delivered as normal, and data_o then holds that word for one extra frame until the next full frame arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the frame rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_dn_ni | input | 1 | Active-low power-down |
| frame_clk_i | input | 1 | Frame clock, sampled on clk_i |
| lane_i | input | 3 | Serial lanes; bit k is lane k |
| data_o | output | 21 | Parallel word |
| strobe_o | output | 1 | Output strobe; rising edge marks valid data |

## Verification
On every cycle, the assertions check four things: the forced-low outputs during reset and power-down, that the strobe is low once the frame clock has been quiet for the loss window, that data_o changes only after a detected frame edge, and that every rising strobe is preceded by a high frame clock. Other behaviour can only be shown by the bench's scenarios, because it needs whole frames to be followed. The bench covers the bit mapping, with a walking one through all 21 positions. It also covers the two-frame latency on arithmetic words, the restart rules after clock loss and after power-down, the exact 15/16-cycle loss boundary, and the discarding of a short frame.

// File: rtl/tri_lane_deser_pkg.sv
package tri_lane_deser_pkg;
  localparam int unsigned DEF_LANES    = 3;
  localparam int unsigned DEF_SLOTS    = 7;
  localparam int unsigned DEF_LOSS_CYC = 16;
endpackage

// File: rtl/tri_lane_frame_trk.sv
module tri_lane_frame_trk #(
  parameter int unsigned SLOTS    = 7,
  parameter int unsigned LOSS_CYC = 16,
  localparam int unsigned SW      = $clog2(SLOTS + 1),
  localparam int unsigned GW      = $clog2(LOSS_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_ni,
  input  logic          frame_clk_i,
  output logic          rise_o,
  output logic          wr_en_o,
  output logic [SW-1:0] idx_o,
  output logic          complete_o,
  output logic          lost_o,
  output logic          fclk_q_o
);
  localparam logic [SW-1:0] SLOT_END = SW'(SLOTS);
  localparam logic [GW-1:0] GAP_END  = GW'(LOSS_CYC);

  logic          fclk_q, seen_q;
  logic [SW-1:0] slot_q;
  logic [GW-1:0] gap_q;

  assign rise_o     = frame_clk_i & ~fclk_q;
  assign lost_o     = (gap_q == GAP_END);
  assign idx_o      = rise_o ? '0 : slot_q;
  assign wr_en_o    = pd_ni & (rise_o | (seen_q & (slot_q != SLOT_END)));
  assign complete_o = seen_q & (slot_q == SLOT_END);
  assign fclk_q_o   = fclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fclk_q <= 1'b0;
      seen_q <= 1'b0;
      slot_q <= '0;
      gap_q  <= '0;
    end else begin
      fclk_q <= frame_clk_i;
      if (!pd_ni) begin
        seen_q <= 1'b0;
        slot_q <= '0;
        gap_q  <= '0;
      end else if (rise_o) begin
        seen_q <= 1'b1;
        slot_q <= SW'(1);
        gap_q  <= '0;
      end else begin
        if (slot_q != SLOT_END) slot_q <= slot_q + 1'b1;
        if (lost_o) seen_q <= 1'b0;
        else        gap_q  <= gap_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tri_lane_capture.sv
module tri_lane_capture #(
  parameter int unsigned SLOTS = 7,
  localparam int unsigned SW   = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             bit_i,
  input  logic             wr_en_i,
  input  logic [SW-1:0]    idx_i,
  output logic [SLOTS-1:0] bits_o
);
  logic [SLOTS-1:0] bits_q;
  assign bits_o = bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bits_q <= '0;
    else if (!pd_ni)  bits_q <= '0;
    else if (wr_en_i) bits_q[idx_i] <= bit_i;
  end
endmodule

// File: rtl/tri_lane_out_stage.sv
module tri_lane_out_stage #(
  parameter int unsigned WORD_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              rise_i,
  input  logic              complete_i,
  input  logic              lost_i,
  input  logic              fclk_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] data_o,
  output logic              strobe_o
);
  logic [WORD_W-1:0] stage_q, data_q;
  logic              sv_q, strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      data_q   <= '0;
      sv_q     <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= fclk_i;
      if (!pd_ni) begin
        stage_q <= '0;
        data_q  <= '0;
        sv_q    <= 1'b0;
      end else if (rise_i) begin
        if (complete_i) stage_q <= word_i;
        sv_q <= complete_i;
        if (sv_q) data_q <= stage_q;
      end else if (lost_i) begin
        sv_q <= 1'b0;
      end
    end
  end

  // power-down gates outputs immediately
  assign data_o   = pd_ni ? data_q : '0;
  assign strobe_o = pd_ni & ~lost_i & strobe_q;
endmodule

// File: rtl/tri_lane_deser.sv
module tri_lane_deser
  import tri_lane_deser_pkg::*;
#(
  parameter int unsigned LANES    = DEF_LANES,
  parameter int unsigned SLOTS    = DEF_SLOTS,
  parameter int unsigned LOSS_CYC = DEF_LOSS_CYC,
  localparam int unsigned WORD_W  = LANES * SLOTS,
  localparam int unsigned SW      = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_dn_ni,
  input  logic              frame_clk_i,
  input  logic [LANES-1:0]  lane_i,
  output logic [WORD_W-1:0] data_o,
  output logic              strobe_o
);
  logic          rise, wr_en, complete, lost, fclk_q;
  logic [SW-1:0] idx;
  logic [WORD_W-1:0] word;

  tri_lane_frame_trk #(.SLOTS(SLOTS), .LOSS_CYC(LOSS_CYC)) trk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_ni      (pwr_dn_ni),
    .frame_clk_i(frame_clk_i),
    .rise_o     (rise),
    .wr_en_o    (wr_en),
    .idx_o      (idx),
    .complete_o (complete),
    .lost_o     (lost),
    .fclk_q_o   (fclk_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tri_lane_capture #(.SLOTS(SLOTS)) cap_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pd_ni  (pwr_dn_ni),
      .bit_i  (lane_i[k]),
      .wr_en_i(wr_en),
      .idx_i  (idx),
      .bits_o (word[k*SLOTS +: SLOTS])
    );
  end

  tri_lane_out_stage #(.WORD_W(WORD_W)) out_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_ni     (pwr_dn_ni),
    .rise_i    (rise),
    .complete_i(complete),
    .lost_i    (lost),
    .fclk_i    (fclk_q),
    .word_i    (word),
    .data_o    (data_o),
    .strobe_o  (strobe_o)
  );
endmodule

// File: rtl/tri_lane_deser_chk.sv
module tri_lane_deser_chk #(
  parameter int unsigned WORD_W   = 21,
  parameter int unsigned LOSS_CYC = 16,
  localparam int unsigned CW      = $clog2(LOSS_CYC + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_dn_ni,
  input logic              frame_clk_i,
  input logic [WORD_W-1:0] data_o,
  input logic              strobe_o
);
  logic          fprev;
  logic [CW-1:0] quiet;
  logic          frise;

  assign frise = frame_clk_i & ~fprev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fprev <= 1'b0;
      quiet <= '0;
    end else begin
      fprev <= frame_clk_i;
      if (!pwr_dn_ni || frise)       quiet <= '0;
      else if (quiet != CW'(LOSS_CYC)) quiet <= quiet + 1'b1;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (data_o == '0 && !strobe_o));

  assert_pd_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |-> (data_o == '0 && !strobe_o));

  assert_loss_strobe_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet == CW'(LOSS_CYC)) |-> !strobe_o);

  assert_data_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_dn_ni && $past(pwr_dn_ni) && !$stable(data_o)) |-> $past(frise));

  assert_strobe_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_o) |-> $past(frame_clk_i, 2));
endmodule

bind tri_lane_deser tri_lane_deser_chk #(.WORD_W(LANES * SLOTS), .LOSS_CYC(LOSS_CYC)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_dn_ni  (pwr_dn_ni),
  .frame_clk_i(frame_clk_i),
  .data_o     (data_o),
  .strobe_o   (strobe_o)
);

// File: tb/tri_lane_deser_tb.sv
module tri_lane_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pd_n = 1'b1;
  logic        fclk = 1'b0;
  logic [2:0]  lanes = '0;
  logic [20:0] data_o;
  logic        strobe_o;
  int          n_vec = 0;
  int          n_err = 0;
  logic [20:0] last1 = '0, last2 = '0;
  localparam logic [20:0] ONES = 21'h1FFFFF;

  always #5 clk = ~clk;

  tri_lane_deser dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_dn_ni(pd_n), .frame_clk_i(fclk),
    .lane_i(lanes), .data_o(data_o), .strobe_o(strobe_o)
  );

  task automatic chk(input string req, input logic [20:0] act, input logic [20:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] wgen(input int m);
    return 21'((m * 32'h0009E377) ^ (m << 13) ^ 32'h00055AA3);
  endfunction

  // one frame: frame clock high for slots 0..3
  task automatic frame(input logic [20:0] w, input int len, input logic [20:0] exp, input string req);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      fclk = (j < 4);
      for (int k = 0; k < 3; k++) lanes[k] = w[7*k + j];
      if (j == 1) chk(req, data_o, exp);
      if (j == 2) chk("R4 strobe high", {20'b0, strobe_o}, 21'd1);
      if (j == 6) begin
        chk("R4 strobe low", {20'b0, strobe_o}, 21'd0);
        chk("R5 stable", data_o, exp);
      end
    end
  endtask

  task automatic send_norm(input logic [20:0] w, input string req);
    frame(w, 7, last2, req);
    last2 = last1;
    last1 = w;
  endtask

  initial begin
    logic [20:0] held;
    repeat (3) @(negedge clk);
    chk("R1 data", data_o, '0);
    chk("R1 strobe", {20'b0, strobe_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 walking one, R3 arithmetic words
    for (int m = 0; m < 61; m++)
      send_norm(m < 21 ? 21'(1 << m) : wgen(m), m < 21 ? "R2" : "R3");

    // R7 loss with frame clock stuck high
    send_norm(21'h0ABCDE, "R3");
    send_norm(21'h154321, "R3");
    held = last2;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      fclk = 1'b1;
      lanes = '0;
      if (c == 1)  chk("R7 held", data_o, held);
      if (c == 16) chk("R7 15 quiet", {20'b0, strobe_o}, 21'd1);
      if (c == 17) chk("R7 16 quiet", {20'b0, strobe_o}, 21'd0);
      if (c == 29) begin
        chk("R7 strobe parked", {20'b0, strobe_o}, 21'd0);
        chk("R7 held late", data_o, held);
      end
    end
    repeat (2) begin @(negedge clk); fclk = 1'b0; end
    frame(21'h0F0F0F, 7, held, "R7 restart");
    frame(21'h13579B, 7, held, "R7 restart");
    frame(21'h02468A, 7, 21'h0F0F0F, "R7 first new");
    last2 = 21'h13579B;
    last1 = 21'h02468A;
    send_norm(21'h1C3A5E, "R3");
    send_norm(21'h00FF00, "R3");

    // R8 power-down
    for (int f = 0; f < 2; f++) begin
      for (int j = 0; j < 7; j++) begin
        @(negedge clk);
        fclk = (j < 4);
        lanes = '1;
        if (f == 0 && j == 0) begin
          pd_n = 1'b0;
          #1 chk("R8 immediate", data_o, '0);
        end
        if (j == 2) chk("R8 strobe", {20'b0, strobe_o}, '0);
        if (j == 6) chk("R8 data", data_o, '0);
      end
    end
    @(negedge clk);
    pd_n = 1'b1;
    fclk = 1'b0;
    frame(21'h0A0A0A, 7, '0, "R8 release");
    frame(21'h050505, 7, '0, "R8 release");
    frame(21'h1E1E1E, 7, 21'h0A0A0A, "R8 first word");
    last2 = 21'h050505;
    last1 = 21'h1E1E1E;

    // R9 short frame
    send_norm(21'h123456, "R3");
    frame(21'h1FEDCB, 6, last2, "R9");
    frame(21'h0BEEF1, 7, 21'h123456, "R9");
    frame(21'h0CAFE2, 7, 21'h123456, "R9 hold");
    frame(21'h0DEAD3, 7, 21'h0BEEF1, "R9 next");
    last2 = 21'h0CAFE2;
    last1 = 21'h0DEAD3;

    // R6 idle lanes high
    for (int i = 0; i < 4; i++) send_norm(ONES, "R6");
    chk("R6 ones", data_o, ONES);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule